// File: doc/BRIEF.md
# Service Request Mailbox

This peripheral lets a host processor hand numbered commands to a service engine and collect the answers. The host places argument words in a 64-word mailbox RAM. It then writes a command word to the control register. That word holds a 7-bit opcode and, above the opcode, the mailbox word offset where the arguments begin. The peripheral raises BUSY for a fixed number of cycles. When BUSY drops, a 16-bit result code is available in the status register, and any response words are in the mailbox. If the request asked for notification, a level interrupt is also raised.

The host can learn of completion in two ways. It can poll BUSY, or it can wait for the interrupt. The interrupt stays high until the host writes zero to a separate interrupt register. A built-in stand-in engine serves three cases:
- an echo opcode, which copies argument words to the response area;
- a sum opcode, which adds the argument words;
- any other opcode, which is rejected with a result code.

A running service can be aborted. While a service runs, the mailbox is locked against host writes and further requests are refused.

The engine is a state machine with five states: ENG_IDLE, ENG_COUNT, ENG_MOVE, ENG_STORE and ENG_HOLD.
- ENG_IDLE to ENG_COUNT: a request is accepted.
- ENG_COUNT reads the argument count word.
- ENG_COUNT to ENG_MOVE: the opcode is echo or sum and the count is nonzero.
- ENG_COUNT to ENG_STORE: the opcode is echo or sum and the count is zero.
- ENG_COUNT to ENG_HOLD: the opcode is unknown.
- ENG_MOVE handles one argument per cycle and goes to ENG_STORE after the last one.
- ENG_STORE writes the sum and then goes to ENG_HOLD.
- ENG_HOLD waits out the remaining latency.
- Any busy state returns to ENG_IDLE when the latency counter reaches LATENCY, or at once on an abort.

Top module: `svc_mailbox`

## Requirements
- R1: Word addresses are fixed as follows:
  - control register: word 0x014 (byte 0x50);
  - status register: word 0x015 (byte 0x54);
  - interrupt register: word 0x016;
  - mailbox window: words 0x200 to 0x23F (byte 0x800 onward).
  
  After reset, every register and mailbox word reads zero and `irq` is low.
- R2: The host starts a service by writing the control register with bit 0 (request) set and bit 2 (abort) clear while the engine is idle. In that word:
  - bits 22:16 are the opcode;
  - bits 31:23 are the argument word offset;
  - bit 3 asks for notification.
  
  Status bit 1 (busy) is high from the cycle after the write for exactly LATENCY cycles.
- R3: The status register reads as follows:
  - bit 1: busy;
  - bit 2: the last service was aborted;
  - bit 3: interrupt pending;
  - bit 0: zero;
  - bits 31:16: the result code.
  
  The result field reads zero while busy, and it is updated on the same edge at which busy falls.
- R4: Opcode 0x01 (echo) takes N from bits 3:0 of the word at the argument offset. It copies the N words that follow to mailbox words 48 to 48+N-1 and finishes with result 0x0000.
- R5: Opcode 0x02 (sum) adds the N words that follow the count word, modulo 2^32. It writes the sum to mailbox word 48 and finishes with result 0x0000.
- R6: Any other opcode finishes after the same LATENCY with result 0x0001.
- R7: `irq` rises on the edge at which busy falls, and only when notification was asked for. It is never high while busy. It stays high until a write of zero to the interrupt register; nonzero writes there have no effect. Accepting a new request drops a pending interrupt. The interrupt register reads `irq` in bit 0.
- R8: A control write with bit 2 set while busy ends the service on the next edge. The service then finishes with result 0x0002 and status bit 2 set, and `irq` rises if notification was asked for.
- R9: A request written while busy is ignored. The stored command word and the completion time are unchanged.
- R10: Host writes to the mailbox while busy are dropped; host reads are allowed at any time.
- R11: Bus reads of unmapped word addresses return zero, and writes to them change nothing. Engine reads beyond the 64 mailbox words return zero.
- R12: The control register reads back as:
  - bits 31:16: the last accepted command word (opcode and offset);
  - bit 3: the notify flag;
  - bit 1: busy;
  - other bits: zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while bus_rd is high, zero otherwise |
| irq | output | 1 | Level completion interrupt |

## Verification
Timing is counted from the cycle in which a request write is held on the bus, which is cycle 0. Busy must read high in cycles 1 through LATENCY. In cycle LATENCY+1 busy must be low, with the result code in place and `irq` at its final value. An abort written in cycle k must show idle status, result 0x0002 and `irq` in cycle k+1. Read data is combinational, so each expected word is queued at the moment its read is driven and compared in the same cycle, on the falling edge. The ignored request and the dropped mailbox write are issued in the middle of a busy window. They are checked through the control readback, the unchanged end cycle and a later mailbox read.

// File: rtl/svc_mbox_pkg.sv
package svc_mbox_pkg;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_COUNT,
        ENG_MOVE,
        ENG_STORE,
        ENG_HOLD
    } eng_state_e;

    localparam int DATA_W   = 32;
    localparam int CMD_W    = 16;
    localparam int OP_W     = 7;
    localparam int OFF_W    = CMD_W - OP_W;
    localparam int CNT_W    = 4;

    localparam int CTRL_WA  = 'h014;
    localparam int STAT_WA  = 'h015;
    localparam int ICLR_WA  = 'h016;

    localparam int BIT_REQ    = 0;
    localparam int BIT_ABORT  = 2;
    localparam int BIT_NOTIFY = 3;

    localparam logic [OP_W-1:0]  OP_ECHO = 7'h01;
    localparam logic [OP_W-1:0]  OP_SUM  = 7'h02;

    localparam logic [CMD_W-1:0] RES_OK    = 16'h0000;
    localparam logic [CMD_W-1:0] RES_BADOP = 16'h0001;
    localparam logic [CMD_W-1:0] RES_ABORT = 16'h0002;

endpackage

// File: rtl/svc_mbox_ram.sv
module svc_mbox_ram #(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    parameter int EAW   = 10,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           h_we,
    input  logic [IW-1:0]  h_idx,
    input  logic [DW-1:0]  h_wdata,
    output logic [DW-1:0]  h_rdata,
    input  logic           e_we,
    input  logic [EAW-1:0] e_waddr,
    input  logic [DW-1:0]  e_wdata,
    input  logic [EAW-1:0] e_raddr,
    output logic [DW-1:0]  e_rdata
);

    logic [DW-1:0] mem [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[w] <= '0;
            end else if (e_we && (e_waddr == EAW'(w))) begin
                mem[w] <= e_wdata;
            end else if (h_we && (h_idx == IW'(w))) begin
                mem[w] <= h_wdata;
            end
        end
    end

    assign h_rdata = mem[h_idx];
    assign e_rdata = (e_raddr < EAW'(DEPTH)) ? mem[e_raddr[IW-1:0]] : '0;

endmodule

// File: rtl/svc_mbox_engine.sv
module svc_mbox_engine
    import svc_mbox_pkg::*;
#(
    parameter int LATENCY   = 32,
    parameter int RESP_BASE = 48,
    parameter int EAW       = 10,
    localparam int TW       = $clog2(LATENCY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [OP_W-1:0]   opcode,
    input  logic [OFF_W-1:0]  offset,
    output logic              busy,
    output logic              fin,
    output logic [CMD_W-1:0]  code,
    output logic [EAW-1:0]    rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [EAW-1:0]    wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    eng_state_e        state, nxt;
    logic [TW-1:0]     timer;
    logic [OP_W-1:0]   op_q;
    logic [OFF_W-1:0]  off_q;
    logic [CNT_W-1:0]  cnt_q, idx_q;
    logic [DATA_W-1:0] acc_q;
    logic [CMD_W-1:0]  code_q;
    logic              known_op, at_limit;

    assign known_op = (op_q == OP_ECHO) || (op_q == OP_SUM);
    assign at_limit = (timer == TW'(LATENCY));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ENG_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ENG_IDLE:  if (start) nxt = ENG_COUNT;
            ENG_COUNT: begin
                if (!known_op)                 nxt = ENG_HOLD;
                else if (rd_data[CNT_W-1:0] == '0) nxt = ENG_STORE;
                else                           nxt = ENG_MOVE;
            end
            ENG_MOVE:  if (idx_q == cnt_q - 1'b1) nxt = ENG_STORE;
            ENG_STORE: nxt = ENG_HOLD;
            ENG_HOLD:  nxt = ENG_HOLD;
            default:   nxt = ENG_IDLE;
        endcase
        if ((state != ENG_IDLE) && (abort || at_limit)) nxt = ENG_IDLE;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer  <= '0;
            op_q   <= '0;
            off_q  <= '0;
            cnt_q  <= '0;
            idx_q  <= '0;
            acc_q  <= '0;
            code_q <= RES_OK;
        end else if (state == ENG_IDLE) begin
            if (start) begin
                timer <= TW'(1);
                op_q  <= opcode;
                off_q <= offset;
                idx_q <= '0;
                acc_q <= '0;
            end
        end else begin
            if (!at_limit) timer <= timer + 1'b1;
            if (state == ENG_COUNT) begin
                cnt_q  <= rd_data[CNT_W-1:0];
                code_q <= known_op ? RES_OK : RES_BADOP;
            end
            if (state == ENG_MOVE) begin
                idx_q <= idx_q + 1'b1;
                if (op_q == OP_SUM) acc_q <= acc_q + rd_data;
            end
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ENG_IDLE);
        fin     = busy && at_limit;
        code    = code_q;
        rd_addr = EAW'(off_q);
        wr_en   = 1'b0;
        wr_addr = EAW'(RESP_BASE);
        wr_data = acc_q;
        unique case (state)
            ENG_MOVE: begin
                rd_addr = EAW'(off_q) + EAW'(1) + EAW'(idx_q);
                if (op_q == OP_ECHO) begin
                    wr_en   = 1'b1;
                    wr_addr = EAW'(RESP_BASE) + EAW'(idx_q);
                    wr_data = rd_data;
                end
            end
            ENG_STORE: wr_en = (op_q == OP_SUM);
            default: ;
        endcase
    end

endmodule

// File: rtl/svc_mbox_regs.sv
module svc_mbox_regs
    import svc_mbox_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DEPTH    = 64,
    parameter int WIN_BASE = 'h200,
    localparam int IW      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    input  logic              busy,
    input  logic              fin,
    input  logic [CMD_W-1:0]  code,
    output logic              start,
    output logic              abort,
    output logic [OP_W-1:0]   opcode,
    output logic [OFF_W-1:0]  offset,
    output logic              ram_we,
    output logic [IW-1:0]     ram_idx,
    input  logic [DATA_W-1:0] ram_rdata
);

    logic [CMD_W-1:0]  sel_q, result_q;
    logic              notify_q, irq_q, aborted_q;
    logic              hit_ctrl, hit_stat, hit_iclr, in_win, ctrl_wr;
    logic [ADDR_W-1:0] woff;

    assign hit_ctrl = (bus_addr == ADDR_W'(CTRL_WA));
    assign hit_stat = (bus_addr == ADDR_W'(STAT_WA));
    assign hit_iclr = (bus_addr == ADDR_W'(ICLR_WA));
    assign woff     = bus_addr - ADDR_W'(WIN_BASE);
    assign in_win   = (bus_addr >= ADDR_W'(WIN_BASE)) && (woff < ADDR_W'(DEPTH));
    assign ram_idx  = woff[IW-1:0];
    assign ram_we   = bus_wr && in_win && !busy;

    assign ctrl_wr  = bus_wr && hit_ctrl;
    assign start    = ctrl_wr && bus_wdata[BIT_REQ] && !bus_wdata[BIT_ABORT] && !busy;
    assign abort    = ctrl_wr && bus_wdata[BIT_ABORT] && busy;
    assign opcode   = bus_wdata[16 +: OP_W];
    assign offset   = bus_wdata[16 + OP_W +: OFF_W];
    assign irq      = irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q     <= '0;
            result_q  <= RES_OK;
            notify_q  <= 1'b0;
            irq_q     <= 1'b0;
            aborted_q <= 1'b0;
        end else if (start) begin
            sel_q     <= bus_wdata[31:16];
            notify_q  <= bus_wdata[BIT_NOTIFY];
            irq_q     <= 1'b0;
            aborted_q <= 1'b0;
        end else if (abort) begin
            result_q  <= RES_ABORT;
            aborted_q <= 1'b1;
            if (notify_q) irq_q <= 1'b1;
        end else if (fin) begin
            result_q  <= code;
            if (notify_q) irq_q <= 1'b1;
        end else if (bus_wr && hit_iclr && (bus_wdata == '0)) begin
            irq_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_ctrl)
                bus_rdata = {sel_q, 12'h0, notify_q, 1'b0, busy, 1'b0};
            else if (hit_stat)
                bus_rdata = {(busy ? 16'h0 : result_q), 12'h0, irq_q, aborted_q, busy, 1'b0};
            else if (hit_iclr)
                bus_rdata = {31'h0, irq_q};
            else if (in_win)
                bus_rdata = ram_rdata;
        end
    end

endmodule

// File: rtl/svc_mailbox.sv
module svc_mailbox
    import svc_mbox_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int MB_DEPTH  = 64,
    parameter int WIN_BASE  = 'h200,
    parameter int RESP_BASE = 48,
    parameter int LATENCY   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    localparam int IW  = $clog2(MB_DEPTH);
    localparam int EAW = OFF_W + 1;

    logic              eng_busy, eng_fin, start, abort, ram_we, e_we;
    logic [CMD_W-1:0]  code;
    logic [OP_W-1:0]   opcode;
    logic [OFF_W-1:0]  offset;
    logic [IW-1:0]     ram_idx;
    logic [DATA_W-1:0] ram_rdata, e_rdata, e_wdata;
    logic [EAW-1:0]    e_raddr, e_waddr;

    svc_mbox_regs #(
        .ADDR_W(ADDR_W), .DEPTH(MB_DEPTH), .WIN_BASE(WIN_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .busy(eng_busy), .fin(eng_fin), .code(code),
        .start(start), .abort(abort), .opcode(opcode), .offset(offset),
        .ram_we(ram_we), .ram_idx(ram_idx), .ram_rdata(ram_rdata)
    );

    svc_mbox_engine #(
        .LATENCY(LATENCY), .RESP_BASE(RESP_BASE), .EAW(EAW)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .opcode(opcode), .offset(offset), .busy(eng_busy), .fin(eng_fin),
        .code(code), .rd_addr(e_raddr), .rd_data(e_rdata),
        .wr_en(e_we), .wr_addr(e_waddr), .wr_data(e_wdata)
    );

    svc_mbox_ram #(
        .DEPTH(MB_DEPTH), .DW(DATA_W), .EAW(EAW)
    ) u_ram (
        .clk(clk), .rst_n(rst_n), .h_we(ram_we), .h_idx(ram_idx),
        .h_wdata(bus_wdata), .h_rdata(ram_rdata), .e_we(e_we),
        .e_waddr(e_waddr), .e_wdata(e_wdata), .e_raddr(e_raddr),
        .e_rdata(e_rdata)
    );

endmodule

// File: rtl/svc_mailbox_chk.sv
module svc_mailbox_chk
    import svc_mbox_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int LATENCY = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              busy,
    input logic              irq
);

    localparam int LW = $clog2(LATENCY + 2);

    logic          ctrl_wr;
    logic [LW-1:0] run_len;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_WA));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            run_len <= '0;
        else if (busy && run_len != '1)        run_len <= run_len + 1'b1;
        else if (!busy)                        run_len <= '0;
    end

    AST_REQ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ctrl_wr && bus_wdata[BIT_REQ] && !bus_wdata[BIT_ABORT]) |=> busy); // R2

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= LW'(LATENCY)); // R2

    AST_FULL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(ctrl_wr && bus_wdata[BIT_ABORT])) |-> (run_len == LW'(LATENCY))); // R6

    AST_IRQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && busy)); // R7

    AST_IRQ_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $fell(busy)); // R7

    AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_wr && bus_wdata[BIT_ABORT]) |=> !busy); // R8

endmodule

bind svc_mailbox svc_mailbox_chk #(.ADDR_W(ADDR_W), .LATENCY(LATENCY)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(eng_busy), .irq(irq)
);

// File: tb/tb_svc_mailbox.sv
`timescale 1ns/1ps
module tb_svc_mailbox;

    localparam int LAT = 32;
    localparam logic [9:0] A_CTRL = 10'h014, A_STAT = 10'h015, A_ICLR = 10'h016;
    localparam logic [9:0] A_WIN  = 10'h200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #4 clk = ~clk;

    svc_mailbox #(.LATENCY(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    typedef struct {
        logic [31:0] data;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;

    function automatic logic [31:0] cw(input logic [8:0] off, input logic [6:0] op,
                                       input logic req, input logic ab, input logic nt);
        return {off, op, 12'h0, nt, ab, 1'b0, req};
    endfunction

    function automatic logic [31:0] st(input logic [15:0] res, input logic ab,
                                       input logic ir, input logic bsy);
        return bsy ? {16'h0, 12'h0, ir, ab, 1'b1, 1'b0}
                   : {res, 12'h0, ir, ab, 1'b0, 1'b0};
    endfunction

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] e, input logic ei,
                      input string tag);
        exp_t it;
        it.data = e; it.irq = ei; it.tag = tag;
        q.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    // monitor: compare queued expectations mid-cycle
    always @(negedge clk) begin
        if (bus_rd) begin
            exp_t e;
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: rdata=%h expected an entry", bus_rdata);
            end else begin
                e = q.pop_front();
                if (bus_rdata !== e.data || irq !== e.irq) begin
                    errors++;
                    $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                             e.tag, bus_rdata, irq, e.data, e.irq);
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1);

        // R1 reset values
        rd(A_CTRL, 32'h0, 1'b0, "R1 ctrl reset");
        rd(A_STAT, 32'h0, 1'b0, "R1 status reset");
        rd(A_ICLR, 32'h0, 1'b0, "R1 irq reg reset");
        rd(A_WIN + 10'd5, 32'h0, 1'b0, "R1 mailbox reset");

        // R11 unmapped bus accesses
        wr(10'h240, 32'hDEAD_BEEF);
        rd(10'h240, 32'h0, 1'b0, "R11 unmapped read above window");
        wr(10'h017, 32'h0000_0123);
        rd(10'h017, 32'h0, 1'b0, "R11 unmapped register read");
        rd(A_WIN, 32'h0, 1'b0, "R11 no alias into mailbox");

        // echo arguments
        wr(A_WIN + 10'd4, 32'd3);
        wr(A_WIN + 10'd5, 32'hAAAA_0001);
        wr(A_WIN + 10'd6, 32'hBBBB_0002);
        wr(A_WIN + 10'd7, 32'hCCCC_0003);
        rd(A_WIN + 10'd5, 32'hAAAA_0001, 1'b0, "R10 host mailbox read");

        // echo run, request in cycle 0
        wr(A_CTRL, cw(9'd4, 7'h01, 1'b1, 1'b0, 1'b1));
        rd(A_STAT, st(16'h0, 1'b0, 1'b0, 1'b1), 1'b0, "R2 busy in cycle 1");            // k=1
        rd(A_CTRL, {9'd4, 7'h01, 12'h0, 1'b1, 1'b0, 1'b1, 1'b0}, 1'b0, "R12 readback"); // k=2
        wr(A_WIN + 10'd10, 32'h0000_0055);                                              // k=3
        wr(A_CTRL, cw(9'd8, 7'h02, 1'b1, 1'b0, 1'b0));                                  // k=4
        rd(A_CTRL, {9'd4, 7'h01, 12'h0, 1'b1, 1'b0, 1'b1, 1'b0}, 1'b0, "R9 request ignored"); // k=5
        idle(LAT - 6);
        rd(A_STAT, st(16'h0, 1'b0, 1'b0, 1'b1), 1'b0, "R2 R9 still busy in cycle LATENCY");
        rd(A_STAT, st(16'h0000, 1'b0, 1'b1, 1'b0), 1'b1, "R3 R7 done with result and irq");
        rd(A_WIN + 10'd48, 32'hAAAA_0001, 1'b1, "R4 echo word 0");
        rd(A_WIN + 10'd49, 32'hBBBB_0002, 1'b1, "R4 echo word 1");
        rd(A_WIN + 10'd50, 32'hCCCC_0003, 1'b1, "R4 echo word 2");
        rd(A_WIN + 10'd10, 32'h0, 1'b1, "R10 write while busy dropped");

        // R7 interrupt clear
        wr(A_ICLR, 32'd5);
        rd(A_ICLR, 32'd1, 1'b1, "R7 nonzero write ignored");
        wr(A_ICLR, 32'd0);
        rd(A_ICLR, 32'd0, 1'b0, "R7 zero write clears");

        // R5 sum with wrap, no notify
        wr(A_WIN + 10'd8,  32'd2);
        wr(A_WIN + 10'd9,  32'hFFFF_FFF0);
        wr(A_WIN + 10'd10, 32'h0000_0025);
        wr(A_CTRL, cw(9'd8, 7'h02, 1'b1, 1'b0, 1'b0));
        idle(LAT);
        rd(A_STAT, st(16'h0000, 1'b0, 1'b0, 1'b0), 1'b0, "R5 R7 sum done, no irq without notify");
        rd(A_WIN + 10'd48, 32'h0000_0015, 1'b0, "R5 sum result");

        // R6 unknown opcode
        wr(A_CTRL, cw(9'd0, 7'h7F, 1'b1, 1'b0, 1'b1));
        idle(LAT - 1);
        rd(A_STAT, st(16'h0, 1'b0, 1'b0, 1'b1), 1'b0, "R6 busy until latency");
        rd(A_STAT, st(16'h0001, 1'b0, 1'b1, 1'b0), 1'b1, "R6 bad opcode result");

        // R8 abort; new request drops pending irq
        wr(A_WIN + 10'd20, 32'd2);
        wr(A_CTRL, cw(9'd20, 7'h01, 1'b1, 1'b0, 1'b1));
        rd(A_STAT, st(16'h0, 1'b0, 1'b0, 1'b1), 1'b0, "R7 accepted request drops irq");
        idle(3);
        wr(A_CTRL, cw(9'd0, 7'h00, 1'b0, 1'b1, 1'b0));
        rd(A_STAT, st(16'h0002, 1'b1, 1'b1, 1'b0), 1'b1, "R8 abort next cycle");

        // R11 engine read past mailbox end
        wr(A_ICLR, 32'd0);
        wr(A_WIN + 10'd60, 32'd5);
        wr(A_WIN + 10'd61, 32'd11);
        wr(A_WIN + 10'd62, 32'd22);
        wr(A_WIN + 10'd63, 32'd33);
        wr(A_WIN + 10'd51, 32'hFFFF);
        wr(A_WIN + 10'd52, 32'hFFFF);
        wr(A_CTRL, cw(9'd60, 7'h01, 1'b1, 1'b0, 1'b0));
        idle(LAT);
        rd(A_STAT, st(16'h0000, 1'b0, 1'b0, 1'b0), 1'b0, "R11 echo near end done");
        rd(A_WIN + 10'd48, 32'd11, 1'b0, "R4 echo near end word 0");
        rd(A_WIN + 10'd50, 32'd33, 1'b0, "R4 echo near end word 2");
        rd(A_WIN + 10'd51, 32'd0, 1'b0, "R11 read past end is zero");
        rd(A_WIN + 10'd52, 32'd0, 1'b0, "R11 read past end is zero");

        idle(2);
        if (q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d entries left, expected 0", q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule